// File: doc/BRIEF.md
# Hardwired Accumulator Fetch-Execute Sequencer

This block is the control and datapath core of a 16-bit single-accumulator machine. It contains a 4096-word memory. A 4-bit step counter is decoded into one-hot timing slots. Fixed register transfers in those slots fetch an instruction word, decode it, resolve one level of indirection and execute the seven memory-operand operations: AND, ADD, LDA, STA, BUN, BSA and ISZ. The core holds the program counter, the address register, the instruction register, the data register, the accumulator, the carry/link bit and the indirect bit.

An instruction word carries the indirect flag in bit 15, the operation code in bits 14:12 and a 12-bit address in bits 11:0. Operation code 111 marks a register or I/O operation, which a neighbouring block executes. In slot T3 this core flags such a word for one cycle and restarts at T0. The core also reports an interrupt request to the interrupt-cycle block.

While the run input is low the core freezes. In that state the memory can be loaded and inspected through a test port.

Top module: `accum_seq_core`

## Requirements
- R1: After reset the step counter reads 0 (slot T0), and the program counter, accumulator and carry bit read 0.
- R2: In T0 the address register takes the program counter. In T1 the instruction register takes the addressed word and the program counter advances by 1. In T2 the address register takes bits 11:0 of the instruction and the indirect bit takes bit 15.
- R3: In T3, when the operation code (bits 14:12) is not 111 and the indirect bit is 1, the address register is replaced by bits 11:0 of the addressed word. When the indirect bit is 0, T3 changes nothing.
- R4: Codes 000 (AND), 001 (ADD) and 010 (LDA) read the operand in T4. In T5 they write AC&operand, AC+operand or the operand into the accumulator, and the step counter returns to 0. ADD writes its carry-out into the carry bit. AND and LDA leave the carry bit unchanged.
- R5: Code 011 (STA) stores the accumulator at the effective address in T4. Code 100 (BUN) loads the program counter with the effective address in T4. Both end the instruction in T4.
- R6: Code 101 (BSA) stores the zero-extended program counter at the effective address. Execution then continues from the effective address plus 1, and the instruction ends in T5.
- R7: Code 110 (ISZ) increments the addressed word and writes it back in T6. If the new value is 0, the program counter advances by 1 more.
- R8: An instruction with code 111 raises rr_io_o for exactly the T3 cycle and returns the step counter to 0. It changes no core register other than those changed by the fetch.
- R9: While run_i is low, every core register and the step counter hold their values. Test-port writes are accepted only in that state. tp_rdata_o always shows the word at tp_addr_i.
- R10: int_req_o is high when ien_i is high, fgi_i or fgo_i is high, and the core is not in T0, T1 or T2.
- R11: The core writes memory only in STA T4, BSA T4 and ISZ T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start-stop flag; low freezes the core |
| tp_we_i | input | 1 | Test-port write strobe (honoured only while stopped) |
| tp_addr_i | input | 12 | Test-port address |
| tp_wdata_i | input | 16 | Test-port write data |
| tp_rdata_o | output | 16 | Word at tp_addr_i |
| ien_i | input | 1 | Interrupt enable from the interrupt block |
| fgi_i | input | 1 | Input-ready flag |
| fgo_i | input | 1 | Output-ready flag |
| rr_io_o | output | 1 | Code 111 seen in T3 |
| int_req_o | output | 1 | Interrupt request |
| sc_o | output | 4 | Step counter |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry bit |

## Verification
A fault in the step counter or the slot decoder shows up at sc_o at the end of the first instruction. The instruction either ends in the wrong slot or never returns to 0. A wrong value in the address or data register reaches the ports later. It appears in pc_o or ac_o when the instruction completes, or in memory contents read back through the test port after the program stops. A comparison at every return of sc_o to 0 places the fault within one instruction. Program paths are chosen so that each effective-address and skip decision alters the next program counter.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_RIO = 3'd7
  } op_e;
endpackage

// File: rtl/accum_timing.sv
module accum_timing #(
  parameter int SC_W = 4,
  localparam int NSLOT = 1 << SC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [SC_W-1:0]  sc_o,
  output logic [NSLOT-1:0] slot_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sc_q <= '0;
    else if (run_i)  sc_q <= clr_i ? '0 : sc_q + 1'b1;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_dec
    assign slot_o[k] = (sc_q == SC_W'(k));
  end

  assign sc_o = sc_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(sc_q));
  assert_one_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_o) == 1);
endmodule

// File: rtl/accum_mem.sv
module accum_mem #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] peek_addr_i,
  output logic [DW-1:0] peek_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o     = mem_q[addr_i];
  assign peek_data_o = mem_q[peek_addr_i];
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] dr_i,
  input  logic          e_i,
  output logic [DW-1:0] ac_o,
  output logic          e_o
);
  always_comb begin
    ac_o = ac_i;
    e_o  = e_i;
    unique case (op_i)
      OP_AND:  ac_o = ac_i & dr_i;
      OP_ADD:  {e_o, ac_o} = {1'b0, ac_i} + {1'b0, dr_i};
      OP_LDA:  ac_o = dr_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_seq_core.sv
module accum_seq_core
  import accum_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int SC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tp_we_i,
  input  logic [AW-1:0]   tp_addr_i,
  input  logic [DW-1:0]   tp_wdata_i,
  output logic [DW-1:0]   tp_rdata_o,
  input  logic            ien_i,
  input  logic            fgi_i,
  input  logic            fgo_i,
  output logic            rr_io_o,
  output logic            int_req_o,
  output logic [SC_W-1:0] sc_o,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   ac_o,
  output logic            e_o
);
  localparam int NSLOT = 1 << SC_W;
  localparam int OP_HI = DW - 2;

  logic [AW-1:0] pc_q, ar_q;
  logic [DW-1:0] ir_q, dr_q, ac_q;
  logic          e_q, i_q;
  logic [NSLOT-1:0] t;
  logic [DW-1:0] mem_rd, core_wd, mem_wd;
  logic [AW-1:0] mem_addr;
  logic          core_we, mem_we, sc_clr, mref;
  logic [DW-1:0] alu_ac;
  logic          alu_e;
  op_e           op;

  assign op   = op_e'(ir_q[OP_HI -: 3]);
  assign mref = (op != OP_RIO);

  accum_timing #(.SC_W(SC_W)) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .clr_i(sc_clr),
    .sc_o(sc_o), .slot_o(t)
  );

  // Last slot of each instruction class
  always_comb begin
    sc_clr = 1'b0;
    if (t[3] && !mref) sc_clr = 1'b1;
    if (t[4] && (op == OP_STA || op == OP_BUN)) sc_clr = 1'b1;
    if (t[5] && (op == OP_AND || op == OP_ADD || op == OP_LDA || op == OP_BSA)) sc_clr = 1'b1;
    if (t[6] && op == OP_ISZ) sc_clr = 1'b1;
  end

  assign core_we = run_i && ((t[4] && (op == OP_STA || op == OP_BSA)) || (t[6] && op == OP_ISZ));

  always_comb begin
    unique case (op)
      OP_STA:  core_wd = ac_q;
      OP_BSA:  core_wd = {{(DW-AW){1'b0}}, pc_q};
      default: core_wd = dr_q;
    endcase
  end

  assign mem_we   = run_i ? core_we : tp_we_i;
  assign mem_addr = run_i ? ar_q : tp_addr_i;
  assign mem_wd   = run_i ? core_wd : tp_wdata_i;

  accum_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .addr_i(mem_addr), .wdata_i(mem_wd),
    .rdata_o(mem_rd), .peek_addr_i(tp_addr_i), .peek_data_o(tp_rdata_o)
  );

  accum_alu #(.DW(DW)) u_alu (
    .op_i(op), .ac_i(ac_q), .dr_i(dr_q), .e_i(e_q), .ac_o(alu_ac), .e_o(alu_e)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0;
      ac_q <= '0; e_q <= 1'b0; i_q <= 1'b0;
    end else if (run_i) begin
      if (t[0]) ar_q <= pc_q;
      if (t[1]) begin
        ir_q <= mem_rd;
        pc_q <= pc_q + 1'b1;
      end
      if (t[2]) begin
        ar_q <= ir_q[AW-1:0];
        i_q  <= ir_q[DW-1];
      end
      if (t[3] && mref && i_q) ar_q <= mem_rd[AW-1:0];
      if (t[4]) begin
        unique case (op)
          OP_AND, OP_ADD, OP_LDA, OP_ISZ: dr_q <= mem_rd;
          OP_BUN: pc_q <= ar_q;
          OP_BSA: ar_q <= ar_q + 1'b1;
          default: ;
        endcase
      end
      if (t[5]) begin
        unique case (op)
          OP_AND, OP_ADD, OP_LDA: begin
            ac_q <= alu_ac;
            e_q  <= alu_e;
          end
          OP_BSA: pc_q <= ar_q;
          OP_ISZ: dr_q <= dr_q + 1'b1;
          default: ;
        endcase
      end
      if (t[6] && op == OP_ISZ && dr_q == '0) pc_q <= pc_q + 1'b1;
    end
  end

  assign rr_io_o   = run_i && t[3] && !mref;
  assign int_req_o = ien_i && (fgi_i || fgo_i) && !(t[0] || t[1] || t[2]);
  assign pc_o = pc_q;
  assign ac_o = ac_q;
  assign e_o  = e_q;

  assert_fetch_ar_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && sc_o == 0 |=> ar_q == $past(pc_q));
  assert_fetch_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && sc_o == 1 |=> pc_q == $past(pc_q) + 1'b1);
  assert_rio_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_io_o |=> sc_o == 0);
  assert_rio_keep_ac_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_io_o |=> $stable(ac_q) && $stable(pc_q));
  assert_write_slot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we |-> (sc_o == 4 || sc_o == 6));
  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q) && $stable(ac_q) && $stable(e_q));
endmodule

// File: tb/accum_seq_core_bench.sv
`timescale 1ns/1ps
module accum_seq_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        tp_we = 1'b0;
  logic [11:0] tp_addr = '0;
  logic [15:0] tp_wdata = '0;
  logic [15:0] tp_rdata;
  logic        ien = 1'b1, fgi = 1'b0, fgo = 1'b1;
  logic        rr_io, int_req, e;
  logic [3:0]  sc;
  logic [11:0] pc;
  logic [15:0] ac;

  int checks = 0, errors = 0;
  int rr_cnt = 0, int_bad = 0;
  bit done = 1'b0, finished = 1'b0;

  typedef struct { logic [11:0] pc; logic [15:0] ac; logic e; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  accum_seq_core u_accum_seq_core (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tp_we_i(tp_we),
    .tp_addr_i(tp_addr), .tp_wdata_i(tp_wdata), .tp_rdata_o(tp_rdata),
    .ien_i(ien), .fgi_i(fgi), .fgo_i(fgo), .rr_io_o(rr_io),
    .int_req_o(int_req), .sc_o(sc), .pc_o(pc), .ac_o(ac), .e_o(e)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    tp_addr = a; tp_wdata = d; tp_we = 1'b1;
    @(negedge clk);
    tp_we = 1'b0;
  endtask

  task automatic expect_step(input logic [11:0] p, input logic [15:0] a, input logic ee);
    exp_t x;
    x.pc = p; x.ac = a; x.e = ee;
    exp_q.push_back(x);
  endtask

  // Monitor: compare at every return of the step counter to T0
  logic [3:0] prev_sc = '0;
  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      if (rr_io) begin
        rr_cnt++;
        if (sc != 4'd3) int_bad++;
      end
      if (int_req != (sc > 4'd2)) int_bad++;
      if (sc == 4'd0 && prev_sc != 4'd0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected instruction end", {20'd0, pc}, 32'd0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(pc == x.pc, "R2/R3/R5/R6/R7 pc at instruction end", {20'd0, pc}, {20'd0, x.pc});
          check(ac == x.ac, "R4 ac at instruction end", {16'd0, ac}, {16'd0, x.ac});
          check(e == x.e, "R4 carry at instruction end", {31'd0, e}, {31'd0, x.e});
          if (exp_q.size() == 0) done = 1'b1;
        end
      end
      prev_sc = sc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sc == 0, "R1 step counter", {28'd0, sc}, 0);
    check(pc == 0, "R1 pc", {20'd0, pc}, 0);
    check(ac == 0 && e == 0, "R1 ac/carry", {15'd0, e, ac}, 0);

    // Program. Word: [15]=indirect, [14:12]=code, [11:0]=address
    poke(12'h000, 16'h2100); // LDA 100
    poke(12'h001, 16'h0101); // AND 101
    poke(12'h002, 16'h1102); // ADD 102
    poke(12'h003, 16'hA103); // LDA @103
    poke(12'h004, 16'h3107); // STA 107
    poke(12'h005, 16'h6106); // ISZ 106 -> FFFF
    poke(12'h006, 16'h6106); // ISZ 106 -> 0000, skip
    poke(12'h007, 16'h2100); // skipped
    poke(12'h008, 16'h5110); // BSA 110
    poke(12'h111, 16'h1101); // ADD 101
    poke(12'h112, 16'hC110); // BUN @110
    poke(12'h009, 16'h7800); // code 111
    poke(12'h00A, 16'h400A); // BUN self
    poke(12'h100, 16'h00FF);
    poke(12'h101, 16'h0F0F);
    poke(12'h102, 16'hFFFF);
    poke(12'h103, 16'h0105);
    poke(12'h105, 16'h1234);
    poke(12'h106, 16'hFFFE);

    // R9: test port readback, core frozen while stopped
    tp_addr = 12'h103;
    #1;
    check(tp_rdata == 16'h0105, "R9 test port readback", {16'd0, tp_rdata}, 32'h0105);
    check(sc == 0 && pc == 0, "R9 frozen before run", {16'd0, sc, pc}, 0);

    expect_step(12'h001, 16'h00FF, 1'b0); // R4 LDA
    expect_step(12'h002, 16'h000F, 1'b0); // R4 AND
    expect_step(12'h003, 16'h000E, 1'b1); // R4 ADD carry
    expect_step(12'h004, 16'h1234, 1'b1); // R3 indirect LDA
    expect_step(12'h005, 16'h1234, 1'b1); // R5 STA
    expect_step(12'h006, 16'h1234, 1'b1); // R7 ISZ no skip
    expect_step(12'h008, 16'h1234, 1'b1); // R7 ISZ skip
    expect_step(12'h111, 16'h1234, 1'b1); // R6 BSA
    expect_step(12'h112, 16'h2143, 1'b0); // R4 ADD no carry
    expect_step(12'h009, 16'h2143, 1'b0); // R3/R5 BUN indirect
    expect_step(12'h00A, 16'h2143, 1'b0); // R8 code 111
    expect_step(12'h00A, 16'h2143, 1'b0); // R5 BUN
    expect_step(12'h00A, 16'h2143, 1'b0);

    @(negedge clk);
    run = 1'b1;
    wait (done);
    @(negedge clk);
    run = 1'b0;

    check(rr_cnt == 1, "R8 rr_io pulses", rr_cnt, 1);
    check(int_bad == 0, "R10 int_req mismatches", int_bad, 0);

    // R9: hold while stopped, with a slot mid-instruction
    begin
      logic [3:0] s0; logic [11:0] p0; logic [15:0] a0;
      @(negedge clk);
      s0 = sc; p0 = pc; a0 = ac;
      repeat (6) @(negedge clk);
      check(sc == s0, "R9 step counter held", {28'd0, sc}, {28'd0, s0});
      check(pc == p0 && ac == a0, "R9 registers held", {pc, ac}, {p0, a0});
    end

    // R10 while stopped: depends on slot
    fgo = 1'b0;
    #1;
    check(int_req == 1'b0, "R10 no flag no request", {31'd0, int_req}, 0);

    tp_addr = 12'h107; #1;
    check(tp_rdata == 16'h1234, "R5 STA stored", {16'd0, tp_rdata}, 32'h1234);
    tp_addr = 12'h106; #1;
    check(tp_rdata == 16'h0000, "R7 ISZ written back", {16'd0, tp_rdata}, 0);
    tp_addr = 12'h110; #1;
    check(tp_rdata == 16'h0009, "R6 BSA return address", {16'd0, tp_rdata}, 32'h0009);
    tp_addr = 12'h100; #1;
    check(tp_rdata == 16'h00FF, "R11 no stray write", {16'd0, tp_rdata}, 32'h00FF);
    tp_addr = 12'h007; #1;
    check(tp_rdata == 16'h2100, "R11 no stray write prog", {16'd0, tp_rdata}, 32'h2100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule